// File: doc/BRIEF.md
# Staged Bus Protection Sequencer

This block raises or drops the bus isolation of one power domain through a short table of protection stages. Each stage owns a byte-wide field of request bits and its own status field. It also has three flags. The inverted flag swaps the meaning of set and clear for that stage. The no-acknowledge flag lets a clear finish without watching status. The alternate flag takes the stage's status from an always-on status input instead of the normal one. The block drives the request bits of one stage at a time, waits until the status of that stage answers, and then moves on to the next stage.

An engage command walks the table from stage 0 upward and ends at the first stage whose request mask is zero. A release command walks from the top stage downward and passes over zero-mask stages without stopping. Every wait for status has a cycle budget. If a stage runs out of budget, the walk aborts at once: the block gives an error pulse and reports the index of the failing stage. Request bits keep their value between commands. The table comes from configuration inputs, which must be stable before a command is issued.

The state machine has six states. S_IDLE waits for a command. S_PICK tests the mask of the current stage and skips or ends on zero. S_DRIVE writes the request bits. S_WAIT polls status against the timeout. S_DONE and S_FAIL each last one cycle and then return to S_IDLE. Its transitions are:

- start: S_IDLE to S_PICK, on a command.
- skip: S_PICK to S_PICK, on release with a zero mask.
- end: S_PICK to S_DONE, on a zero mask during engage, or at stage 0 during release.
- write: S_PICK to S_DRIVE.
- no-wait: S_DRIVE to S_PICK or S_DONE, on a clear without acknowledge.
- poll: S_DRIVE to S_WAIT.
- advance: S_WAIT to S_PICK or S_DONE, when the status matches.
- abort: S_WAIT to S_FAIL, when the budget runs out.
- return: S_DONE or S_FAIL to S_IDLE.

Top module: `bprot_seq`

## Requirements
- R1: After reset, prot_req_o is all zero and busy_o, done_o and err_o are low.
- R2: Engage handles stages in rising index order (stage k owns bits [8k+7:8k] of every per-stage bus). It ends with done at the first stage whose request mask is zero, and stages above that stage are left untouched.
- R3: Release handles stages from the highest index down to 0. It passes over zero-mask stages and continues to the stages below them.
- R4: A set ORs the stage mask into the stage's request field. It then waits until every status bit selected by the stage's status mask reads one.
- R5: A clear removes the mask bits from the request field. It then waits until the masked status reads zero. When the stage's alternate flag (cfg_alt_i bit k) is high, the status is read from alt_sta_i instead and must read all ones under the mask, for both set and clear.
- R6: A stage whose inverted flag (cfg_inv_i bit k) is high performs a clear during engage and a set during release.
- R7: A clear on a stage whose no-acknowledge flag (cfg_noack_i bit k) is high completes without waiting on status, even if the status never matches.
- R8: If status does not match within TMO_CYC wait cycles, the walk aborts. err_o pulses, fail_stage_o holds the stage index, later stages are left untouched, and the request bits already written are kept.
- R9: prot_req_o changes only while a command is being processed. Changes to status or configuration while idle leave it unchanged.
- R10: If engage and release are asserted in the same idle cycle, engage is taken and release is dropped. Commands that arrive while busy_o is high are ignored.
- R11: done_o and err_o are one-cycle pulses that never occur together, and busy_o is low in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| engage_i | input | 1 | Start an engage walk (sampled while idle) |
| release_i | input | 1 | Start a release walk (sampled while idle) |
| cfg_set_mask_i | input | N_STG*MW | Per-stage request mask, zero marks a table end |
| cfg_sta_mask_i | input | N_STG*MW | Per-stage status mask |
| cfg_inv_i | input | N_STG | Per-stage inverted polarity flag |
| cfg_noack_i | input | N_STG | Per-stage flag: clear needs no acknowledge |
| cfg_alt_i | input | N_STG | Per-stage flag: status from the always-on source |
| sta_i | input | N_STG*MW | Normal per-stage status |
| alt_sta_i | input | N_STG*MW | Always-on per-stage status |
| prot_req_o | output | N_STG*MW | Held protection request bits |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse: walk completed |
| err_o | output | 1 | One-cycle pulse: walk aborted on timeout |
| fail_stage_o | output | IDX_W | Index of the stage that last timed out |

## Verification
Two events can fall in the same cycle: an engage command and a release command, both seen while idle. The bench provokes this by pulsing engage_i and release_i in the same cycle, with a table in which only engage changes the request bits. The result is judged from the final value of prot_req_o. The bench also pulses a command in the middle of a walk and checks that no second walk follows. A status stub copies the request bits back into sta_i after a programmable latency, with forced-high and forced-low bits added to provoke timeouts and acknowledge-free clears. The order in which stages are visited is recovered by watching which request byte changes in each cycle.

// File: rtl/bprot_pkg.sv
package bprot_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_DRIVE,
        S_WAIT,
        S_DONE,
        S_FAIL
    } bp_state_e;

    typedef enum logic {
        DIR_ENG,
        DIR_REL
    } bp_dir_e;

endpackage

// File: rtl/bprot_req_bank.sv
// Held request fields, one register per stage; a write touches only the addressed field.
module bprot_req_bank #(
    parameter int N_STG = 4,
    parameter int MW    = 8,
    localparam int IDX_W = (N_STG > 1) ? $clog2(N_STG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_set,
    input  logic [MW-1:0]         wr_mask,
    output logic [N_STG*MW-1:0]   req_o
);

    for (genvar k = 0; k < N_STG; k++) begin : g_stage
        logic [MW-1:0] fld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                if (wr_set) begin
                    fld_q <= fld_q | wr_mask;
                end else begin
                    fld_q <= fld_q & ~wr_mask;
                end
            end
        end

        assign req_o[k*MW +: MW] = fld_q;
    end

endmodule

// File: rtl/bprot_ack_chk.sv
// Decides whether the selected status source answers the pending operation.
module bprot_ack_chk #(
    parameter int MW = 8
) (
    input  logic [MW-1:0] sta_i,
    input  logic [MW-1:0] alt_sta_i,
    input  logic [MW-1:0] sta_mask_i,
    input  logic          use_alt_i,
    input  logic          want_set_i,
    output logic          match_o
);

    logic [MW-1:0] src;
    logic [MW-1:0] target;

    always_comb begin
        src     = use_alt_i ? alt_sta_i : sta_i;
        // Alternate source reads all ones for both directions.
        target  = (want_set_i || use_alt_i) ? sta_mask_i : '0;
        match_o = ((src & sta_mask_i) == target);
    end

endmodule

// File: rtl/bprot_wait_tmr.sv
// Counts cycles spent waiting for status; flags the last allowed cycle.
module bprot_wait_tmr #(
    parameter int TMO_CYC = 250000000,
    localparam int TW = $clog2(TMO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);

    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // R8: the wait counter never passes its budget
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/bprot_seq.sv
module bprot_seq
    import bprot_pkg::*;
#(
    parameter int N_STG   = 4,
    parameter int MW      = 8,
    parameter int TMO_CYC = 250000000,
    localparam int IDX_W  = (N_STG > 1) ? $clog2(N_STG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  engage_i,
    input  logic                  release_i,
    input  logic [N_STG*MW-1:0]   cfg_set_mask_i,
    input  logic [N_STG*MW-1:0]   cfg_sta_mask_i,
    input  logic [N_STG-1:0]      cfg_inv_i,
    input  logic [N_STG-1:0]      cfg_noack_i,
    input  logic [N_STG-1:0]      cfg_alt_i,
    input  logic [N_STG*MW-1:0]   sta_i,
    input  logic [N_STG*MW-1:0]   alt_sta_i,
    output logic [N_STG*MW-1:0]   prot_req_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic [IDX_W-1:0]      fail_stage_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STG - 1);

    bp_state_e        st_q, st_d;
    bp_dir_e          dir_q, dir_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             set_q, set_d;
    logic [IDX_W-1:0] fail_q;

    logic [MW-1:0]    cur_mask, cur_sta_mask, cur_sta, cur_alt_sta;
    logic             cur_inv, cur_noack, cur_alt;
    logic             op_set_now, last_stg, match, expired;
    logic [IDX_W-1:0] step_idx;

    // Current stage view
    always_comb begin
        cur_mask     = cfg_set_mask_i[idx_q*MW +: MW];
        cur_sta_mask = cfg_sta_mask_i[idx_q*MW +: MW];
        cur_sta      = sta_i[idx_q*MW +: MW];
        cur_alt_sta  = alt_sta_i[idx_q*MW +: MW];
        cur_inv      = cfg_inv_i[idx_q];
        cur_noack    = cfg_noack_i[idx_q];
        cur_alt      = cfg_alt_i[idx_q];
        op_set_now   = (dir_q == DIR_ENG) ^ cur_inv;
        last_stg     = (dir_q == DIR_ENG) ? (idx_q == LAST_IDX) : (idx_q == '0);
        step_idx     = (dir_q == DIR_ENG) ? idx_q + 1'b1 : idx_q - 1'b1;
    end

    bprot_req_bank #(.N_STG(N_STG), .MW(MW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_q == S_DRIVE),
        .wr_idx  (idx_q),
        .wr_set  (op_set_now),
        .wr_mask (cur_mask),
        .req_o   (prot_req_o)
    );

    bprot_ack_chk #(.MW(MW)) u_ack (
        .sta_i      (cur_sta),
        .alt_sta_i  (cur_alt_sta),
        .sta_mask_i (cur_sta_mask),
        .use_alt_i  (cur_alt),
        .want_set_i (set_q),
        .match_o    (match)
    );

    bprot_wait_tmr #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (st_q == S_DRIVE),
        .run_i     (st_q == S_WAIT),
        .expired_o (expired)
    );

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        dir_d = dir_q;
        idx_d = idx_q;
        set_d = set_q;
        unique case (st_q)
            S_IDLE: begin
                if (engage_i) begin
                    dir_d = DIR_ENG;
                    idx_d = '0;
                    st_d  = S_PICK;
                end else if (release_i) begin
                    dir_d = DIR_REL;
                    idx_d = LAST_IDX;
                    st_d  = S_PICK;
                end
            end
            S_PICK: begin
                if (cur_mask == '0) begin
                    if (dir_q == DIR_ENG || idx_q == '0) begin
                        st_d = S_DONE;
                    end else begin
                        idx_d = idx_q - 1'b1;
                    end
                end else begin
                    st_d = S_DRIVE;
                end
            end
            S_DRIVE: begin
                set_d = op_set_now;
                if (!op_set_now && cur_noack) begin
                    if (last_stg) begin
                        st_d = S_DONE;
                    end else begin
                        idx_d = step_idx;
                        st_d  = S_PICK;
                    end
                end else begin
                    st_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (match) begin
                    if (last_stg) begin
                        st_d = S_DONE;
                    end else begin
                        idx_d = step_idx;
                        st_d  = S_PICK;
                    end
                end else if (expired) begin
                    st_d = S_FAIL;
                end
            end
            S_DONE:  st_d = S_IDLE;
            S_FAIL:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            dir_q  <= DIR_ENG;
            idx_q  <= '0;
            set_q  <= 1'b0;
            fail_q <= '0;
        end else begin
            st_q  <= st_d;
            dir_q <= dir_d;
            idx_q <= idx_d;
            set_q <= set_d;
            if (st_q == S_WAIT && !match && expired) begin
                fail_q <= idx_q;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o       = (st_q != S_IDLE);
        done_o       = (st_q == S_DONE);
        err_o        = (st_q == S_FAIL);
        fail_stage_o = fail_q;
    end

    // R11: completion and abort never coincide
    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R11: one-cycle done pulse, then idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R9: request bits hold while idle
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |=> $stable(prot_req_o));

    // R2: engage ends at a zero-mask stage
    a_r2_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PICK && dir_q == DIR_ENG && cur_mask == '0) |=> (st_q == S_DONE));

    // R7: acknowledge-free clear never enters the wait
    a_r7_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DRIVE && !op_set_now && cur_noack) |=> (st_q != S_WAIT));

endmodule

// File: tb/test_bprot_seq.sv
`timescale 1ns/1ps
module test_bprot_seq;

    localparam int N_STG = 4;
    localparam int MW    = 8;
    localparam int TMO   = 40;
    localparam int W     = N_STG * MW;

    typedef struct packed {
        logic          eng;
        logic [W-1:0]  msk;
        logic [3:0]    inv;
        logic [3:0]    nak;
        logic [3:0]    alt;
        logic [W-1:0]  shi;
        logic [W-1:0]  slo;
        logic [W-1:0]  xreq;
        logic          xerr;
        logic [1:0]    xfs;
        logic [2:0]    xn;
        logic [7:0]    xord;
    } vec_t;

    // Order field: visited stage j at xord[2j+:2]
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R2 R4: engage stops at zero stage 2
        '{1'b1, 32'hC000_300F, 4'h0, 4'h0, 4'h0, 32'h0, 32'h0, 32'h0000_300F, 1'b0, 2'd0, 3'd2, 8'h04},
        // R3 R5: release skips stage 2
        '{1'b0, 32'hC000_300F, 4'h0, 4'h0, 4'h0, 32'h0, 32'h0, 32'h0000_0000, 1'b0, 2'd0, 3'd2, 8'h01},
        // R6: inverted stage 2 clears on engage
        '{1'b1, 32'h0804_0201, 4'h4, 4'h0, 4'h0, 32'h0, 32'h0, 32'h0800_0201, 1'b0, 2'd0, 3'd3, 8'h34},
        // R6 R3: inverted stage 2 sets on release
        '{1'b0, 32'h0804_0201, 4'h4, 4'h0, 4'h0, 32'h0, 32'h0, 32'h0004_0000, 1'b0, 2'd0, 3'd4, 8'h1B},
        // R7: no-ack clear with status stuck high
        '{1'b0, 32'h0004_0000, 4'h0, 4'h4, 4'h0, 32'h0004_0000, 32'h0, 32'h0, 1'b0, 2'd0, 3'd1, 8'h00 | 8'h02},
        // R5: alternate source for set, main stuck low
        '{1'b1, 32'h0000_0011, 4'h0, 4'h0, 4'h1, 32'h0, 32'h0000_0011, 32'h0000_0011, 1'b0, 2'd0, 3'd1, 8'h00},
        // R5: alternate source for clear, main stuck high
        '{1'b0, 32'h0000_0011, 4'h0, 4'h0, 4'h1, 32'h0000_0011, 32'h0, 32'h0, 1'b0, 2'd0, 3'd1, 8'h00},
        // R8: stage 1 never acknowledges
        '{1'b1, 32'h0004_0201, 4'h0, 4'h0, 4'h0, 32'h0, 32'h0000_0200, 32'h0000_0201, 1'b1, 2'd1, 3'd2, 8'h04},
        // R3: cleanup after abort
        '{1'b0, 32'h0004_0201, 4'h0, 4'h0, 4'h0, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0, 3'd2, 8'h01}
    };
    string vtag [NV] = '{"R2", "R3", "R6", "R6", "R7", "R5", "R5", "R8", "R3"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic engage_i = 1'b0, release_i = 1'b0;
    logic [W-1:0] cfg_msk = '0;
    logic [N_STG-1:0] cfg_inv = '0, cfg_nak = '0, cfg_alt = '0;
    logic [W-1:0] sta, alt_sta, prot_req;
    logic busy_o, done_o, err_o;
    logic [1:0] fail_stage;

    logic [W-1:0] stk_hi = '0, stk_lo = '0;
    logic [W-1:0] hist [8];
    int lat = 3;

    int checks = 0, errors = 0;
    int nch = 0;
    int ordlog [8];
    logic [W-1:0] prev = '0;
    bit got_done, got_err, pulse_ok;
    logic [1:0] got_fs;

    always #2 clk = ~clk;

    assign alt_sta = '1;

    bprot_seq #(.N_STG(N_STG), .MW(MW), .TMO_CYC(TMO)) i_bprot_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .engage_i       (engage_i),
        .release_i      (release_i),
        .cfg_set_mask_i (cfg_msk),
        .cfg_sta_mask_i (cfg_msk),
        .cfg_inv_i      (cfg_inv),
        .cfg_noack_i    (cfg_nak),
        .cfg_alt_i      (cfg_alt),
        .sta_i          (sta),
        .alt_sta_i      (alt_sta),
        .prot_req_o     (prot_req),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .fail_stage_o   (fail_stage)
    );

    // Status stub: echo of requests after lat cycles, plus forced bits
    always @(posedge clk) begin
        hist[0] <= prot_req;
        for (int i = 1; i < 8; i++) hist[i] <= hist[i-1];
    end
    always_comb begin
        sta = (((lat == 0) ? prot_req : hist[lat-1]) | stk_hi) & ~stk_lo;
    end

    // Stage visit recorder
    always @(negedge clk) begin
        for (int k = 0; k < N_STG; k++) begin
            if (prot_req[k*MW +: MW] !== prev[k*MW +: MW]) begin
                if (nch < 8) ordlog[nch] = k;
                nch++;
            end
        end
        prev = prot_req;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input bit eng, input bit rel);
        int cyc;
        nch = 0;
        engage_i = eng;
        release_i = rel;
        @(negedge clk);
        engage_i = 1'b0;
        release_i = 1'b0;
        cyc = 0;
        while (!(done_o || err_o) && cyc < 600) begin
            @(negedge clk);
            cyc++;
        end
        got_done = done_o;
        got_err = err_o;
        got_fs = fail_stage;
        @(negedge clk);
        pulse_ok = !done_o && !err_o && !busy_o;
    endtask

    task automatic apply_vec(input vec_t v);
        cfg_msk = v.msk;
        cfg_inv = v.inv;
        cfg_nak = v.nak;
        cfg_alt = v.alt;
        stk_hi = v.shi;
        stk_lo = v.slo;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t v;
        bit ord_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(prot_req == '0, "R1", "reset req", prot_req, '0);
        check(!busy_o && !done_o && !err_o, "R1", "reset flags",
              {busy_o, done_o, err_o}, '0);

        // Table walk at two stub latencies
        for (int pass = 0; pass < 2; pass++) begin
            lat = (pass == 0) ? 3 : 0;
            for (int n = 0; n < NV; n++) begin
                v = VECS[n];
                apply_vec(v);
                run_op(v.eng, !v.eng);
                check(prot_req == v.xreq, vtag[n], "final req", prot_req, v.xreq);
                check(got_done == !v.xerr && got_err == v.xerr, vtag[n], "done/err",
                      {got_done, got_err}, {!v.xerr, v.xerr});
                if (v.xerr)
                    check(got_fs == v.xfs, "R8", "fail stage", got_fs, v.xfs);
                ord_ok = (nch == v.xn);
                for (int j = 0; j < 4; j++)
                    if (j < v.xn && ordlog[j] != v.xord[2*j +: 2]) ord_ok = 1'b0;
                check(ord_ok, vtag[n], "stage order/count", nch, v.xn);
                // R11: single pulse then idle
                check(pulse_ok, "R11", "pulse width", {done_o, err_o, busy_o}, '0);
            end
        end
        stk_hi = '0;
        stk_lo = '0;
        cfg_inv = '0;
        cfg_nak = '0;
        cfg_alt = '0;
        lat = 3;

        // R10: simultaneous engage and release, engage wins
        cfg_msk = 32'h0000_0005;
        run_op(1'b1, 1'b1);
        check(prot_req == 32'h5, "R10", "same-cycle commands", prot_req, 32'h5);

        // R10: command while busy is dropped
        nch = 0;
        release_i = 1'b1;
        @(negedge clk);
        release_i = 1'b0;
        @(negedge clk);
        engage_i = 1'b1;
        @(negedge clk);
        engage_i = 1'b0;
        repeat (30) @(negedge clk);
        check(prot_req == '0 && !busy_o, "R10", "busy command ignored",
              prot_req, '0);

        // R9: idle hold under status and config changes
        cfg_msk = 32'h0000_0003;
        run_op(1'b1, 1'b0);
        check(prot_req == 32'h3, "R4", "set field", prot_req, 32'h3);
        stk_hi = 32'hFFFF_FFFF;
        cfg_msk = 32'h0F0F_0F0F;
        cfg_inv = 4'hF;
        repeat (20) @(negedge clk);
        check(prot_req == 32'h3, "R9", "idle hold", prot_req, 32'h3);
        stk_lo = 32'hFFFF_FFFF;
        repeat (10) @(negedge clk);
        check(prot_req == 32'h3 && !busy_o, "R9", "idle hold 2", prot_req, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule